// File: doc/BRIEF.md
# Burst-Window Power-Down Control Register

This block is a single 10-bit read/write control word for a baseband codec, decoded at register address 7 on a simple parallel register bus with an address, a write strobe, write data and combinational read data. It switches off three consumers: the uplink path, the downlink path and the mid-rail reference driver. For each consumer a mode bit picks the power-down source. It is either the live burst timing window (transmit window for uplink and mid-rail, receive window for downlink) or a static power-down bit written by software.

The same word also drives four level controls straight from its bits: a codec reset that stays asserted until software clears it, a calibration-mode select, an I/Q loopback enable and a common-mode level select. The window inputs are asynchronous. Each one passes through a two-flop synchronizer, and the three power-down outputs come from registers.

Top module: `pwrdn_ctrl_reg`

## Requirements
- R1: After reset the word reads 0x0000 at address 7. Codec reset, calibration select, loopback and common-mode select outputs are 0.
- R2: A write to any address other than 7 leaves the word and all outputs unchanged. A read of any address other than 7 returns 0.
- R3: A read of address 7 returns the word in bits 9..0 and 0 in every higher bit. Bits 9..0 hold, in order: cm_sel, loop_en, mid_static, mid_pd, ul_static, ul_pd, dl_static, dl_pd, ext_cal, codec_rst. A write stores only wdata bits 9..0.
- R4: With ul_static (bit 5) at 1, ul_pd_o equals ul_pd (bit 4) whatever the transmit window does.
- R5: With ul_static at 0, ul_pd_o is 1 while the synchronized transmit window is low and 0 while it is high.
- R6: With dl_static (bit 3) at 1, dl_pd_o equals dl_pd (bit 2). With dl_static at 0, dl_pd_o is the inverse of the synchronized receive window.
- R7: With mid_static (bit 7) at 1, mid_pd_o equals mid_pd (bit 6). With mid_static at 0, mid_pd_o is the inverse of the synchronized transmit window.
- R8: codec_rst_o follows bit 0 as a level. It stays at 1 across any number of cycles until a write to address 7 clears bit 0.
- R9: ext_cal_o, loop_en_o and cm_sel_o equal bits 1, 8 and 9 from the clock edge that writes them.
- R10: A power-down output changes on the clock edge after the write that changes its source. A window input change shows at the output on the third rising edge after it.
- R11: During and right after reset all three power-down outputs are 1.
- R12: When a mode-bit write lands on the same edge as a synchronized window change, the power-down output on the next edge uses the newly written mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| tx_win_i | input | 1 | Transmit burst window, asynchronous, high = active |
| rx_win_i | input | 1 | Receive burst window, asynchronous, high = active |
| ul_pd_o | output | 1 | Uplink path power-down |
| dl_pd_o | output | 1 | Downlink path power-down |
| mid_pd_o | output | 1 | Mid-rail driver power-down |
| codec_rst_o | output | 1 | Codec reset level, active high |
| ext_cal_o | output | 1 | 1 = external calibration, 0 = auto-calibration |
| loop_en_o | output | 1 | I/Q uplink-to-downlink loopback enable |
| cm_sel_o | output | 1 | Common-mode select, 1 = fixed level, 0 = half supply |

## Verification
A software write that flips a path's mode bit and a transmit-window edge leaving the synchronizer can land on the same clock edge. To provoke this, the bench drops the window while the uplink is in window mode. It then times a write of static mode with ul_pd = 0 so that the word updates on the edge where the synchronized window falls. The check is that ul_pd_o stays 0 on every following edge. A design that used the old mode for even one cycle would show a 1 pulse.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int CTRL_W    = 10;
  localparam int NUM_PATHS = 3;
  localparam int NUM_WIN   = 2;

  localparam int PATH_UL  = 0;
  localparam int PATH_DL  = 1;
  localparam int PATH_MID = 2;

  localparam int WIN_TX = 0;
  localparam int WIN_RX = 1;

  // bit order is the readback layout
  typedef struct packed {
    logic cm_sel;
    logic loop_en;
    logic mid_static;
    logic mid_pd;
    logic ul_static;
    logic ul_pd;
    logic dl_static;
    logic dl_pd;
    logic ext_cal;
    logic codec_rst;
  } ctrl_t;
endpackage

// File: rtl/pwrdn_regfile.sv
module pwrdn_regfile
  import pwrdn_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int REG_ADDR = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic  hit;
  ctrl_t ctrl_q;

  assign hit = (addr_i == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_q <= '0;
    else if (we_i && hit) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign rdata_o = hit ? {{PAD_W{1'b0}}, ctrl_q} : '0;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwrdn_sel.sv
module pwrdn_sel #(
  parameter int NPATH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPATH-1:0] win_i,
  input  logic [NPATH-1:0] static_mode_i,
  input  logic [NPATH-1:0] static_pd_i,
  output logic [NPATH-1:0] pd_o
);
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic pd_d, pd_q;
    // window low = powered down
    assign pd_d = static_mode_i[p] ? static_pd_i[p] : ~win_i[p];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pd_q <= 1'b1;
      else         pd_q <= pd_d;
    end
    assign pd_o[p] = pd_q;
  end
endmodule

// File: rtl/pwrdn_ctrl_reg.sv
module pwrdn_ctrl_reg
  import pwrdn_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int REG_ADDR    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_win_i,
  input  logic              rx_win_i,
  output logic              ul_pd_o,
  output logic              dl_pd_o,
  output logic              mid_pd_o,
  output logic              codec_rst_o,
  output logic              ext_cal_o,
  output logic              loop_en_o,
  output logic              cm_sel_o
);
  ctrl_t                ctrl_q;
  logic [NUM_WIN-1:0]   win_raw, win_s;
  logic [NUM_PATHS-1:0] path_win, path_mode, path_spd, path_pd;

  pwrdn_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
  ) u_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ctrl_o(ctrl_q)
  );

  assign win_raw[WIN_TX] = tx_win_i;
  assign win_raw[WIN_RX] = rx_win_i;

  pwrdn_sync #(.WIDTH(NUM_WIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(win_raw), .q_o(win_s)
  );

  assign path_win[PATH_UL]   = win_s[WIN_TX];
  assign path_win[PATH_DL]   = win_s[WIN_RX];
  assign path_win[PATH_MID]  = win_s[WIN_TX];
  assign path_mode[PATH_UL]  = ctrl_q.ul_static;
  assign path_mode[PATH_DL]  = ctrl_q.dl_static;
  assign path_mode[PATH_MID] = ctrl_q.mid_static;
  assign path_spd[PATH_UL]   = ctrl_q.ul_pd;
  assign path_spd[PATH_DL]   = ctrl_q.dl_pd;
  assign path_spd[PATH_MID]  = ctrl_q.mid_pd;

  pwrdn_sel #(.NPATH(NUM_PATHS)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_i(path_win),
    .static_mode_i(path_mode), .static_pd_i(path_spd), .pd_o(path_pd)
  );

  assign ul_pd_o     = path_pd[PATH_UL];
  assign dl_pd_o     = path_pd[PATH_DL];
  assign mid_pd_o    = path_pd[PATH_MID];
  assign codec_rst_o = ctrl_q.codec_rst;
  assign ext_cal_o   = ctrl_q.ext_cal;
  assign loop_en_o   = ctrl_q.loop_en;
  assign cm_sel_o    = ctrl_q.cm_sel;
endmodule

// File: rtl/pwrdn_ctrl_reg_chk.sv
module pwrdn_ctrl_reg_chk
  import pwrdn_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int REG_ADDR = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input ctrl_t             ctrl,
  input logic [NUM_WIN-1:0] win_s,
  input logic              ul_pd_o,
  input logic              dl_pd_o,
  input logic              mid_pd_o,
  input logic              codec_rst_o
);
  logic hit;
  assign hit = (addr_i == ADDR_W'(REG_ADDR));

  p_foreign_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(ctrl));

  p_foreign_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == '0));

  p_ul_static_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.ul_static |=> (ul_pd_o == $past(ctrl.ul_pd)));

  p_ul_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.ul_static |=> (ul_pd_o == !$past(win_s[WIN_TX])));

  p_dl_static_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.dl_static |=> (dl_pd_o == $past(ctrl.dl_pd)));

  p_dl_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.dl_static |=> (dl_pd_o == !$past(win_s[WIN_RX])));

  p_mid_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mid_pd_o == ($past(ctrl.mid_static) ? $past(ctrl.mid_pd)
                                                   : !$past(win_s[WIN_TX]))));

  p_rst_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit) |=> $stable(codec_rst_o));
endmodule

bind pwrdn_ctrl_reg pwrdn_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .rdata_o(rdata_o), .ctrl(ctrl_q), .win_s(win_s), .ul_pd_o(ul_pd_o),
  .dl_pd_o(dl_pd_o), .mid_pd_o(mid_pd_o), .codec_rst_o(codec_rst_o)
);

// File: tb/pwrdn_ctrl_reg_test.sv
`timescale 1ns/1ps
module pwrdn_ctrl_reg_test;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int NVEC   = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic tx = 1'b0, rx = 1'b0;
  logic ul, dl, mid, crst, ecal, lpen, cms;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwrdn_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tx_win_i(tx), .rx_win_i(rx), .ul_pd_o(ul), .dl_pd_o(dl),
    .mid_pd_o(mid), .codec_rst_o(crst), .ext_cal_o(ecal), .loop_en_o(lpen),
    .cm_sel_o(cms)
  );

  // {word[9:0], tx, rx, exp_ul, exp_dl, exp_mid}
  localparam logic [14:0] VEC [NVEC] = '{
    {10'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {10'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {10'h0A8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'h0FC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {10'h030, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {10'h00C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {10'h0C0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {10'h080, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'h303, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 4'd7;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    addr = 4'd7;
    wait_n(3);
    check("R11 ul reset", 16'(ul), 16'h1);
    check("R11 dl reset", 16'(dl), 16'h1);
    check("R11 mid reset", 16'(mid), 16'h1);
    rst_ni = 1'b1;
    wait_n(1);
    check("R1 reset readback", rdata, 16'h0000);
    check("R1 reset levels", 16'({cms, lpen, ecal, crst}), 16'h0);
    check("R11 pd after reset", 16'({ul, dl, mid}), 16'h7);

    for (int i = 0; i < NVEC; i++) begin
      tx = VEC[i][4]; rx = VEC[i][3];
      write(4'd7, DATA_W'(VEC[i][14:5]));
      wait_n(4);
      check("R4 R5 ul vector", 16'(ul), 16'(VEC[i][2]));
      check("R6 dl vector", 16'(dl), 16'(VEC[i][1]));
      check("R7 mid vector", 16'(mid), 16'(VEC[i][0]));
      check("R3 readback vector", rdata, DATA_W'(VEC[i][14:5]));
      check("R9 level bits", 16'({cms, lpen, ecal}),
            16'({VEC[i][14], VEC[i][13], VEC[i][6]}));
    end

    // R2: foreign address write and read
    write(4'd7, 16'h00A8);
    write(4'd3, 16'h03FF);
    wait_n(3);
    check("R2 word kept", rdata, 16'h00A8);
    check("R2 outputs kept", 16'({ul, dl, mid, crst, cms}), 16'h0);
    addr = 4'd3;
    wait_n(1);
    check("R2 foreign read", rdata, 16'h0000);
    addr = 4'd7;

    // R3: upper wdata bits dropped
    write(4'd7, 16'hFFFF);
    check("R3 zero extend", rdata, 16'h03FF);

    // R8: level reset held then released
    write(4'd7, 16'h0001);
    check("R8 reset set", 16'(crst), 16'h1);
    wait_n(10);
    check("R8 reset held", 16'(crst), 16'h1);
    write(4'd7, 16'h0000);
    check("R8 reset cleared", 16'(crst), 16'h0);

    // R10: window latency, all window mode, tx low settled
    tx = 1'b0;
    wait_n(4);
    check("R10 pre", 16'(ul), 16'h1);
    tx = 1'b1;
    wait_n(1); check("R10 edge1", 16'(ul), 16'h1);
    wait_n(1); check("R10 edge2", 16'(ul), 16'h1);
    wait_n(1); check("R10 edge3", 16'(ul), 16'h0);

    // R10: write latency, static pd=1
    @(negedge clk); addr = 4'd7; wdata = 16'h0030; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R10 write same edge", 16'(ul), 16'h0);
    @(negedge clk);
    check("R10 write next edge", 16'(ul), 16'h1);

    // R12: mode write coincides with synced window fall
    write(4'd7, 16'h0000);
    tx = 1'b1;
    wait_n(4);
    check("R12 pre", 16'(ul), 16'h0);
    tx = 1'b0;
    @(negedge clk); wdata = 16'h0020; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R12 edge2", 16'(ul), 16'h0);
    @(negedge clk); check("R12 edge3", 16'(ul), 16'h0);
    @(negedge clk); check("R12 edge4", 16'(ul), 16'h0);
    check("R12 mid window", 16'(mid), 16'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule